// File: doc/BRIEF.md
# Im2col Convolution Address Generator

This block produces the read sequence that lowers a batch-one convolution into a matrix product. The input feature map sits in an external memory in height-width-channel order. A start pulse captures the input height, width and channel count, the kernel height and width, the output height and width, the stride and the zero-padding amount. The block then emits one tuple per accepted cycle. Each tuple holds a memory address, the lowered-matrix row it belongs to, its column, and a flag that marks a sample lying in the zero border.

The lowered matrix has one row per output position. Output rows advance fastest along the output width. Inside a row, every window sample of one input channel is emitted before the next channel starts. Within a channel the kernel rows come outer and the kernel columns inner. A weight matrix stored kernel by kernel, channel-major, therefore lines up with each row, and a matrix engine can consume the stream as it is generated.

Addresses follow `((h*W_in)+w)*C_in + c`. The inner loops reach them through additions only; the multiplies happen once, when the configuration is captured. A valid/ready pair throttles the stream. Row-end and matrix-end markers, followed by a done pulse, frame the output.

Top module: `im2col_addr_gen`

## Requirements
- R1: After reset, and whenever rst_ni is low, valid_o, done_o and busy_o are 0.
- R2: A start_i pulse while busy_o is 0 captures all configuration inputs, and the first tuple (row 0, column 0) is valid on the next cycle. A start_i pulse, or a change on the configuration inputs, while the stream runs has no effect on the tuples that follow.
- R3: row_o equals oh*OUT_W + ow. Rows are emitted in increasing order, with ow inner and oh outer.
- R4: col_o equals c*K_H*K_W + kh*K_W + kw and runs from 0 to K_H*K_W*C_in-1 within each row. The loops nest c outer, then kh, then kw innermost.
- R5: For a sample inside the image, addr_o equals ((h*IN_W)+w)*IN_C + c, where h = oh*stride - pad + kh and w = ow*stride - pad + kw.
- R6: pad_o is 1 exactly when h < 0, h >= IN_H, w < 0 or w >= IN_W. addr_o is not defined while pad_o is 1.
- R7: While valid_o is 1 and ready_i is 0, addr_o, row_o, col_o, pad_o and the markers hold their values, and no element is skipped.
- R8: row_last_o is 1 on the last column of every row.
- R9: mat_last_o is 1 only on the final tuple, with row_last_o also 1. done_o pulses for exactly one cycle on the cycle after that tuple is accepted, valid_o is 0 during the pulse, and busy_o falls on the following cycle. The total number of tuples is OUT_H*OUT_W*K_H*K_W*C_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new lowering pass; ignored while busy |
| in_h_i | input | DIM_W | Input feature map height (>=1) |
| in_w_i | input | DIM_W | Input feature map width (>=1) |
| in_ch_i | input | DIM_W | Input channel count (>=1) |
| k_h_i | input | DIM_W | Kernel height (>=1) |
| k_w_i | input | DIM_W | Kernel width (>=1) |
| out_h_i | input | DIM_W | Output height (>=1) |
| out_w_i | input | DIM_W | Output width (>=1) |
| stride_i | input | STR_W | Stride in both directions (>=1) |
| pad_i | input | STR_W | Zero border width on every side |
| ready_i | input | 1 | Consumer accepts the current tuple |
| valid_o | output | 1 | Tuple on the outputs is valid |
| addr_o | output | ADDR_W | Input memory word address |
| row_o | output | 2*DIM_W | Lowered-matrix row index |
| col_o | output | 3*DIM_W | Lowered-matrix column index |
| pad_o | output | 1 | Sample lies in the zero border |
| row_last_o | output | 1 | Last column of the current row |
| mat_last_o | output | 1 | Final tuple of the matrix |
| done_o | output | 1 | One-cycle pulse after the final tuple is accepted |
| busy_o | output | 1 | A pass is in progress |

## Verification
The final tuple raises the row-end marker, the matrix-end marker and the last-column condition in the same cycle. In the single-element shape this is also the first tuple, so the start, the first element and the end all fall within two cycles. Every tuple in every table shape is checked for both markers. The single-element shape and the done timing show that the end of a row and the end of the matrix do not clash. A second overlap is a start pulse, with different configuration values, arriving in the middle of a stalled stream. The following tuples are compared against the original shape's expected sequence to confirm the pulse was ignored.

// File: rtl/im2col_pkg.sv
`timescale 1ns/1ps
package im2col_pkg;
  localparam int unsigned NUM_LVL = 5;
  // loop levels, innermost first
  localparam int unsigned LVL_KW = 0;
  localparam int unsigned LVL_KH = 1;
  localparam int unsigned LVL_CH = 2;
  localparam int unsigned LVL_OW = 3;
  localparam int unsigned LVL_OH = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gen_state_e;
endpackage

// File: rtl/im2col_loop_nest.sv
`timescale 1ns/1ps
module im2col_loop_nest
  import im2col_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              step_i,
  input  logic [NUM_LVL-1:0][CNT_W-1:0]     lim_i,
  output logic [NUM_LVL-1:0]                adv_o,
  output logic                              row_end_o,
  output logic                              all_end_o
);
  logic [CNT_W-1:0]   cnt_q [NUM_LVL];
  logic [NUM_LVL-1:0] at_last;
  logic [NUM_LVL:0]   chain;

  assign chain[0] = 1'b1;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    assign at_last[i]   = (cnt_q[i] == lim_i[i]);
    assign chain[i+1]   = chain[i] & at_last[i];
    // exactly the lowest non-final level advances; all below it wrap
    assign adv_o[i]     = step_i & chain[i] & ~at_last[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q[i] <= '0;
      else if (clear_i)             cnt_q[i] <= '0;
      else if (step_i && chain[i])  cnt_q[i] <= at_last[i] ? '0 : cnt_q[i] + CNT_W'(1);
    end

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[i] <= lim_i[i]); // R4
  end

  assign row_end_o = chain[LVL_OW];
  assign all_end_o = chain[NUM_LVL];

  AST_ADV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adv_o)); // R4
endmodule

// File: rtl/im2col_coord.sv
`timescale 1ns/1ps
module im2col_coord
  import im2col_pkg::*;
#(
  parameter int unsigned DIM_W = 8,
  parameter int unsigned STR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STR_W-1:0]   stride_i,
  input  logic [STR_W-1:0]   pad_amt_i,
  input  logic [DIM_W-1:0]   ih_i,
  input  logic [DIM_W-1:0]   iw_i,
  input  logic [NUM_LVL-1:0] adv_i,
  output logic               outside_o
);
  localparam int unsigned CW = DIM_W + STR_W + 2;

  logic signed [CW-1:0] h0_q, w0_q, h_q, w_q;
  logic signed [CW-1:0] pad_s, str_s, ih_s, iw_s;
  logic signed [CW-1:0] w0_nxt, h0_nxt;

  assign pad_s  = signed'(CW'(pad_amt_i));
  assign str_s  = signed'(CW'(stride_i));
  assign ih_s   = signed'(CW'(ih_i));
  assign iw_s   = signed'(CW'(iw_i));
  assign w0_nxt = w0_q + str_s;
  assign h0_nxt = h0_q + str_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0;
      w0_q <= '0;
      h_q  <= '0;
      w_q  <= '0;
    end else if (load_i) begin
      h0_q <= -pad_s;
      w0_q <= -pad_s;
      h_q  <= -pad_s;
      w_q  <= -pad_s;
    end else if (adv_i[LVL_KW]) begin
      w_q  <= w_q + CW'(1);
    end else if (adv_i[LVL_KH]) begin
      h_q  <= h_q + CW'(1);
      w_q  <= w0_q;
    end else if (adv_i[LVL_CH]) begin
      h_q  <= h0_q;
      w_q  <= w0_q;
    end else if (adv_i[LVL_OW]) begin
      w0_q <= w0_nxt;
      w_q  <= w0_nxt;
      h_q  <= h0_q;
    end else if (adv_i[LVL_OH]) begin
      h0_q <= h0_nxt;
      h_q  <= h0_nxt;
      w0_q <= -pad_s;
      w_q  <= -pad_s;
    end
  end

  assign outside_o = (h_q < 0) || (h_q >= ih_s) || (w_q < 0) || (w_q >= iw_s);
endmodule

// File: rtl/im2col_addr_acc.sv
`timescale 1ns/1ps
module im2col_addr_acc
  import im2col_pkg::*;
#(
  parameter int unsigned SAW = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SAW-1:0]     base_i,
  input  logic [SAW-1:0]     ch_step_i,
  input  logic [SAW-1:0]     row_step_i,
  input  logic [SAW-1:0]     win_step_i,
  input  logic [SAW-1:0]     out_step_i,
  input  logic [NUM_LVL-1:0] adv_i,
  output logic [SAW-1:0]     addr_o
);
  // modulo-2^SAW arithmetic; bases of padded windows go negative
  logic [SAW-1:0] row_q, win_q, chan_q, khb_q, addr_q;
  logic [SAW-1:0] khb_nxt, chan_nxt, win_nxt, row_nxt;

  assign khb_nxt  = khb_q + row_step_i;
  assign chan_nxt = chan_q + SAW'(1);
  assign win_nxt  = win_q + win_step_i;
  assign row_nxt  = row_q + out_step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      win_q  <= '0;
      chan_q <= '0;
      khb_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      row_q  <= base_i;
      win_q  <= base_i;
      chan_q <= base_i;
      khb_q  <= base_i;
      addr_q <= base_i;
    end else if (adv_i[LVL_KW]) begin
      addr_q <= addr_q + ch_step_i;
    end else if (adv_i[LVL_KH]) begin
      khb_q  <= khb_nxt;
      addr_q <= khb_nxt;
    end else if (adv_i[LVL_CH]) begin
      chan_q <= chan_nxt;
      khb_q  <= chan_nxt;
      addr_q <= chan_nxt;
    end else if (adv_i[LVL_OW]) begin
      win_q  <= win_nxt;
      chan_q <= win_nxt;
      khb_q  <= win_nxt;
      addr_q <= win_nxt;
    end else if (adv_i[LVL_OH]) begin
      row_q  <= row_nxt;
      win_q  <= row_nxt;
      chan_q <= row_nxt;
      khb_q  <= row_nxt;
      addr_q <= row_nxt;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/im2col_addr_gen.sv
`timescale 1ns/1ps
module im2col_addr_gen
  import im2col_pkg::*;
#(
  parameter  int unsigned DIM_W  = 8,
  parameter  int unsigned STR_W  = 4,
  parameter  int unsigned ADDR_W = 20,
  localparam int unsigned ROW_W  = 2 * DIM_W,
  localparam int unsigned COL_W  = 3 * DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  in_h_i,
  input  logic [DIM_W-1:0]  in_w_i,
  input  logic [DIM_W-1:0]  in_ch_i,
  input  logic [DIM_W-1:0]  k_h_i,
  input  logic [DIM_W-1:0]  k_w_i,
  input  logic [DIM_W-1:0]  out_h_i,
  input  logic [DIM_W-1:0]  out_w_i,
  input  logic [STR_W-1:0]  stride_i,
  input  logic [STR_W-1:0]  pad_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              pad_o,
  output logic              row_last_o,
  output logic              mat_last_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned SAW = ADDR_W + 2;

  gen_state_e state_q;

  logic [DIM_W-1:0] ih_q, iw_q, ic_q, kh_q, kw_q, oh_q, ow_q;
  logic [STR_W-1:0] stride_q, pad_q;
  logic [SAW-1:0]   row_step_q, win_step_q, out_step_q;
  logic [COL_W-1:0] col_last_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  logic             load, fire, row_end, all_end;
  logic [NUM_LVL-1:0]            adv;
  logic [NUM_LVL-1:0][DIM_W-1:0] lim;
  logic [SAW-1:0]   row_step_d, win_step_d, out_step_d, base_d, addr_s;
  logic [COL_W-1:0] col_last_d;

  // one-time products at configuration capture
  assign row_step_d = SAW'(in_w_i) * SAW'(in_ch_i);
  assign win_step_d = SAW'(stride_i) * SAW'(in_ch_i);
  assign out_step_d = SAW'(stride_i) * row_step_d;
  assign base_d     = SAW'(0) - SAW'(pad_i) * (row_step_d + SAW'(in_ch_i));
  assign col_last_d = COL_W'(k_h_i) * COL_W'(k_w_i) * COL_W'(in_ch_i) - COL_W'(1);

  assign load = (state_q == ST_IDLE) && start_i;
  assign fire = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i)          state_q <= ST_RUN;
        ST_RUN:  if (fire && all_end)  state_q <= ST_DONE;
        default:                       state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ih_q       <= '0;
      iw_q       <= '0;
      ic_q       <= '0;
      kh_q       <= '0;
      kw_q       <= '0;
      oh_q       <= '0;
      ow_q       <= '0;
      stride_q   <= '0;
      pad_q      <= '0;
      row_step_q <= '0;
      win_step_q <= '0;
      out_step_q <= '0;
      col_last_q <= '0;
    end else if (load) begin
      ih_q       <= in_h_i;
      iw_q       <= in_w_i;
      ic_q       <= in_ch_i;
      kh_q       <= k_h_i;
      kw_q       <= k_w_i;
      oh_q       <= out_h_i;
      ow_q       <= out_w_i;
      stride_q   <= stride_i;
      pad_q      <= pad_i;
      row_step_q <= row_step_d;
      win_step_q <= win_step_d;
      out_step_q <= out_step_d;
      col_last_q <= col_last_d;
    end
  end

  // lowered-matrix tags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= '0;
      col_q <= '0;
    end else if (fire) begin
      col_q <= row_end ? '0 : col_q + COL_W'(1);
      if (row_end) row_q <= row_q + ROW_W'(1);
    end
  end

  assign lim[LVL_KW] = kw_q - DIM_W'(1);
  assign lim[LVL_KH] = kh_q - DIM_W'(1);
  assign lim[LVL_CH] = ic_q - DIM_W'(1);
  assign lim[LVL_OW] = ow_q - DIM_W'(1);
  assign lim[LVL_OH] = oh_q - DIM_W'(1);

  im2col_loop_nest #(.CNT_W(DIM_W)) u_nest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load),
    .step_i    (fire),
    .lim_i     (lim),
    .adv_o     (adv),
    .row_end_o (row_end),
    .all_end_o (all_end)
  );

  im2col_coord #(.DIM_W(DIM_W), .STR_W(STR_W)) u_coord (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .stride_i  (load ? stride_i : stride_q),
    .pad_amt_i (load ? pad_i : pad_q),
    .ih_i      (ih_q),
    .iw_i      (iw_q),
    .adv_i     (adv),
    .outside_o (pad_o)
  );

  im2col_addr_acc #(.SAW(SAW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (base_d),
    .ch_step_i  (SAW'(ic_q)),
    .row_step_i (row_step_q),
    .win_step_i (win_step_q),
    .out_step_i (out_step_q),
    .adv_i      (adv),
    .addr_o     (addr_s)
  );

  assign valid_o    = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign busy_o     = (state_q != ST_IDLE);
  assign row_last_o = valid_o && row_end;
  assign mat_last_o = valid_o && all_end;
  assign addr_o     = addr_s[ADDR_W-1:0];
  assign row_o      = row_q;
  assign col_o      = col_q;

  AST_FIRST_TUPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> valid_o && row_o == '0 && col_o == '0); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && start_i && !(ready_i && mat_last_o) |=> valid_o); // R2
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(row_o) && $stable(col_o)
      && $stable(pad_o) && $stable(row_last_o) && $stable(mat_last_o)); // R7
  AST_ADDR_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !pad_o |-> !addr_s[SAW-1]); // R5
  AST_ROWLAST_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_last_o |-> col_o == col_last_q); // R8
  AST_MATLAST_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mat_last_o |-> row_last_o); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && mat_last_o |=> done_o && !valid_o); // R9
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9
endmodule

// File: tb/tb_im2col_addr_gen.sv
`timescale 1ns/1ps
module tb_im2col_addr_gen;
  localparam int DIM_W  = 8;
  localparam int STR_W  = 4;
  localparam int ADDR_W = 20;

  typedef struct packed {
    int ih; int iw; int ic; int kh; int kw; int st; int pd; int oh; int ow; int total;
    logic [7:0] rmask;
  } shape_t;

  // ih iw ic kh kw st pd oh ow total ready-pattern
  localparam shape_t TBL [5] = '{
    '{4, 4, 1, 3, 3, 1, 0, 2, 2,  36, 8'hFF},
    '{5, 5, 2, 3, 3, 2, 1, 3, 3, 162, 8'hB6},
    '{3, 4, 3, 2, 2, 1, 1, 4, 5, 240, 8'hDD},
    '{1, 1, 1, 1, 1, 1, 0, 1, 1,   1, 8'h01},
    '{6, 3, 2, 1, 3, 2, 1, 4, 2,  48, 8'h55}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [DIM_W-1:0] in_h_i = '0, in_w_i = '0, in_ch_i = '0, k_h_i = '0, k_w_i = '0;
  logic [DIM_W-1:0] out_h_i = '0, out_w_i = '0;
  logic [STR_W-1:0] stride_i = '0, pad_i = '0;
  logic ready_i = 1'b0;
  logic valid_o, pad_o, row_last_o, mat_last_o, done_o, busy_o;
  logic [ADDR_W-1:0]  addr_o;
  logic [2*DIM_W-1:0] row_o;
  logic [3*DIM_W-1:0] col_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  im2col_addr_gen #(.DIM_W(DIM_W), .STR_W(STR_W), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .in_h_i(in_h_i), .in_w_i(in_w_i), .in_ch_i(in_ch_i), .k_h_i(k_h_i), .k_w_i(k_w_i),
    .out_h_i(out_h_i), .out_w_i(out_w_i), .stride_i(stride_i), .pad_i(pad_i),
    .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o), .row_o(row_o), .col_o(col_o),
    .pad_o(pad_o), .row_last_o(row_last_o), .mat_last_o(mat_last_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_tuple(input shape_t s, input int k,
                           output int e_row, output int e_col, output int e_addr,
                           output bit e_pad, output bit e_rl, output bit e_ml);
    int cols, o_h, o_w, c, r, k_h, k_w, h, w;
    cols  = s.kh * s.kw * s.ic;
    e_row = k / cols;
    e_col = k % cols;
    o_h   = e_row / s.ow;
    o_w   = e_row % s.ow;
    c     = e_col / (s.kh * s.kw);
    r     = e_col % (s.kh * s.kw);
    k_h   = r / s.kw;
    k_w   = r % s.kw;
    h     = o_h * s.st - s.pd + k_h;
    w     = o_w * s.st - s.pd + k_w;
    e_pad = (h < 0) || (h >= s.ih) || (w < 0) || (w >= s.iw);
    e_addr = ((h * s.iw) + w) * s.ic + c;
    e_rl  = (e_col == cols - 1);
    e_ml  = e_rl && (e_row == s.oh * s.ow - 1);
  endtask

  task automatic drive_cfg(input shape_t s);
    in_h_i   = DIM_W'(s.ih);
    in_w_i   = DIM_W'(s.iw);
    in_ch_i  = DIM_W'(s.ic);
    k_h_i    = DIM_W'(s.kh);
    k_w_i    = DIM_W'(s.kw);
    out_h_i  = DIM_W'(s.oh);
    out_w_i  = DIM_W'(s.ow);
    stride_i = STR_W'(s.st);
    pad_i    = STR_W'(s.pd);
  endtask

  task automatic run_shape(input int idx, input bit poke);
    shape_t s;
    int k, guard, cyc, e_row, e_col, e_addr;
    int h_addr, h_row, h_col;
    bit e_pad, e_rl, e_ml, rdy, stalled, poked;
    s = TBL[idx];
    k = 0; guard = 0; cyc = 0; stalled = 0; poked = 0;
    h_addr = 0; h_row = 0; h_col = 0;
    @(negedge clk);
    drive_cfg(s);
    ready_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o == 1'b1, "R2 first tuple valid", int'(valid_o), 1);
    while (k < s.total && guard < 4000) begin
      guard++;
      if (valid_o) begin
        exp_tuple(s, k, e_row, e_col, e_addr, e_pad, e_rl, e_ml);
        if (stalled)
          check(int'(addr_o) == h_addr && int'(row_o) == h_row && int'(col_o) == h_col,
                "R7 hold during stall", int'(col_o), h_col);
        check(int'(row_o) == e_row, "R3 row tag", int'(row_o), e_row);
        check(int'(col_o) == e_col, "R4 column tag", int'(col_o), e_col);
        check(pad_o == e_pad, "R6 pad flag", int'(pad_o), int'(e_pad));
        if (!e_pad) check(int'(addr_o) == e_addr, "R5 address", int'(addr_o), e_addr);
        check(row_last_o == e_rl, "R8 row end", int'(row_last_o), int'(e_rl));
        check(mat_last_o == e_ml, "R9 matrix end", int'(mat_last_o), int'(e_ml));
        rdy = s.rmask[cyc % 8];
        cyc++;
        ready_i = rdy;
        if (!rdy) begin
          stalled = 1'b1;
          h_addr = int'(addr_o); h_row = int'(row_o); h_col = int'(col_o);
        end else begin
          stalled = 1'b0;
          k++;
        end
        if (poke && k == 20 && !poked) begin
          // foreign start and config mid-stream: must be ignored (R2)
          start_i = 1'b1;
          in_h_i = 8'd9; in_w_i = 8'd2; in_ch_i = 8'd5; k_w_i = 8'd1;
          stride_i = 4'd3; pad_i = 4'd2;
          poked = 1'b1;
        end else begin
          start_i = 1'b0;
        end
      end else begin
        check(1'b0, "R2 valid held during stream", int'(valid_o), 1);
      end
      @(negedge clk);
    end
    ready_i = 1'b0;
    start_i = 1'b0;
    check(k == s.total, "R9 tuple count", k, s.total);
    check(done_o == 1'b1, "R9 done pulse", int'(done_o), 1);
    check(valid_o == 1'b0, "R9 valid low at done", int'(valid_o), 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
    check(busy_o == 1'b0, "R9 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && busy_o == 1'b0, "R1 idle after reset", int'(busy_o), 0);

    for (int i = 0; i < 5; i++) run_shape(i, i == 1);

    // reset in the middle of a stream
    @(negedge clk);
    drive_cfg(TBL[0]);
    ready_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(valid_o == 1'b0, "R1 valid cleared by reset", int'(valid_o), 0);
    check(busy_o == 1'b0, "R1 busy cleared by reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1 done cleared by reset", int'(done_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    ready_i = 1'b0;
    run_shape(3, 1'b0);
    run_shape(1, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule